// File: doc/BRIEF.md
# Decimating Six-Channel Input Sequencer

This block spreads a stream of words that arrive one at a time on a shared bus across a row of channel registers. It suits a column driver that takes the words for several adjacent columns, one per pixel-clock edge. Each channel has two stages. The load stage fills as the sequence walks the channels. The output stage changes only when a transfer strobe copies every load stage into it at the same moment. The channel outputs therefore stay steady while the next set of words is loaded.

The pixel clock is represented by one clock, `clk2x`, that runs at twice the pixel rate, plus an internal phase. After standby is released, the first `clk2x` edge stands for a pixel-clock rising edge. The edges after it alternate falling, rising, and so on. An edge-select input sets which kind of pixel edge captures data. A direction input sets whether loading walks upward or downward through the channels. The start strobe is sampled one active edge ahead of the capture it triggers. A transfer requested at a rising edge commits on the falling edge that follows it. Standby wipes all stored state.

Top module: `dseq_top`

## Requirements
- R1: While `standby` is high, every load-stage register, every output-stage register, the start arm, the pending transfer and the busy flag clear to zero on each `clk2x` edge. The first `clk2x` edge with `standby` low is a pixel rising edge. Edges after it alternate falling, rising, and so on.
- R2: When `edge_rise` is 1, captures happen only on pixel rising edges. When `edge_rise` is 0, captures happen only on pixel falling edges. `edge_rise` is sampled at each edge.
- R3: `start_req` is sampled at every active edge. If it was 1 at the previous active edge, the current active edge captures `din` into the first channel.
- R4: With `load_fwd`=1 at the start edge, the channels fill in the order 0,1,...,N-1. With `load_fwd`=0, they fill in the order N-1,...,0. Channel k occupies bits [k*W +: W] of `chan_code`.
- R5: The direction is latched at the start edge. A change of `load_fwd` in the middle of a sequence has no effect on that sequence's order.
- R6: After the N-th capture of a sequence, the block captures nothing more until a new start. Load stages that are not being captured keep their values.
- R7: An armed start that arrives while a sequence is running restarts the sequence at the first channel for the current `load_fwd`.
- R8: If `xfer_req` is 1 at a pixel rising edge, all N load stages are copied into the output stages on the next `clk2x` edge, which is a falling edge. At any other time the output stages hold their values.
- R9: When a transfer and a capture fall on the same falling edge, the transferred data includes the word captured at that edge.
- R10: `seq_busy` goes high at the first capture of a sequence. It stays high until the edge of the N-th capture, and falls at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Clock at twice the pixel rate; each edge is one pixel-clock edge |
| standby | input | 1 | Synchronous clear of all state while high |
| din | input | W | Shared input word bus |
| start_req | input | 1 | Start strobe, takes effect at the next active edge |
| edge_rise | input | 1 | 1: capture on pixel rising edges, 0: capture on pixel falling edges |
| load_fwd | input | 1 | 1: fill channels upward, 0: fill channels downward |
| xfer_req | input | 1 | Transfer strobe, sampled at pixel rising edges |
| chan_code | output | N*W | Output-stage words, channel k at bits [k*W +: W] |
| seq_busy | output | 1 | Sequence active, more captures pending |

## Verification
Some properties are checked by assertions on every cycle. These are that standby clears state, that at most one channel captures per edge, that load and output stages move only when enabled, that the busy flag drops after the last step, and that pixel phases alternate. Other behaviour can only be shown by the bench's scenarios. This covers the order of channel fills in each direction, the direction staying latched mid-sequence, restarts, and a transfer that coincides with a capture carrying the new word. It also covers the capture timing under both edge-select settings. The bench checks this with a reference model that steps once per `clk2x` edge, driven by mixed random and directed stimulus.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

   // Map a sequence step to the channel it fills, for a given direction.
   function automatic int chan_of_step(input int step, input logic fwd, input int n);
      return fwd ? step : (n - 1 - step);
   endfunction

endpackage

// File: rtl/dseq_phase.sv
module dseq_phase (
   input  logic clk2x,
   input  logic standby,
   input  logic edge_rise,
   output logic rise_ev,
   output logic fall_ev,
   output logic act_ev
);
   logic phase_q;

   always_ff @(posedge clk2x) begin
      if (standby) phase_q <= 1'b0;
      else         phase_q <= ~phase_q;
   end

   assign rise_ev = !standby && !phase_q;
   assign fall_ev = !standby &&  phase_q;
   assign act_ev  = edge_rise ? rise_ev : fall_ev;

   AST_PHASE_ALTERNATES: assert property (@(posedge clk2x) disable iff (standby)
      rise_ev |=> !rise_ev); // R1
   AST_FIRST_IS_RISE: assert property (@(posedge clk2x)
      standby |=> (standby || rise_ev)); // R1
endmodule

// File: rtl/dseq_ctrl.sv
module dseq_ctrl #(
   parameter int N = 6
) (
   input  logic         clk2x,
   input  logic         standby,
   input  logic         act_ev,
   input  logic         start_req,
   input  logic         load_fwd,
   output logic [N-1:0] cap_en,
   output logic         busy
);
   import dseq_pkg::*;

   localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

   logic             arm_q;
   logic             busy_q;
   logic             dir_q;
   logic [IDX_W-1:0] step_q;

   always_ff @(posedge clk2x) begin
      if (standby) begin
         arm_q  <= 1'b0;
         busy_q <= 1'b0;
         dir_q  <= 1'b0;
         step_q <= '0;
      end else if (act_ev) begin
         arm_q <= start_req;
         if (arm_q) begin
            dir_q  <= load_fwd;
            step_q <= IDX_W'(1 % N);
            busy_q <= (N > 1);
         end else if (busy_q) begin
            busy_q <= (int'(step_q) != N - 1);
            step_q <= (int'(step_q) == N - 1) ? '0 : step_q + 1'b1;
         end
      end
   end

   generate
      for (genvar i = 0; i < N; i++) begin : g_en
         always_comb begin
            cap_en[i] = 1'b0;
            if (act_ev) begin
               if (arm_q)
                  cap_en[i] = (chan_of_step(0, load_fwd, N) == i);
               else if (busy_q)
                  cap_en[i] = (chan_of_step(int'(step_q), dir_q, N) == i);
            end
         end
      end
   endgenerate

   assign busy = busy_q;

   AST_ONE_CAPTURE: assert property (@(posedge clk2x) disable iff (standby)
      $onehot0(cap_en)); // R6
   AST_BUSY_ENDS: assert property (@(posedge clk2x) disable iff (standby)
      (act_ev && !arm_q && busy_q && int'(step_q) == N - 1) |=> !busy_q); // R10
   AST_IDLE_QUIET: assert property (@(posedge clk2x) disable iff (standby)
      (!arm_q && !busy_q) |-> (cap_en == '0)); // R6
   AST_START_BUSY: assert property (@(posedge clk2x) disable iff (standby)
      (act_ev && arm_q) |=> busy_q); // R10
endmodule

// File: rtl/dseq_chan.sv
module dseq_chan #(
   parameter int W = 10
) (
   input  logic         clk2x,
   input  logic         standby,
   input  logic         cap,
   input  logic [W-1:0] din,
   input  logic         xfer_now,
   output logic [W-1:0] hold
);
   logic [W-1:0] load_q;
   logic [W-1:0] load_nx;
   logic [W-1:0] hold_q;

   assign load_nx = cap ? din : load_q;

   always_ff @(posedge clk2x) begin
      if (standby) begin
         load_q <= '0;
         hold_q <= '0;
      end else begin
         load_q <= load_nx;
         if (xfer_now) hold_q <= load_nx;
      end
   end

   assign hold = hold_q;

   AST_HOLD_STABLE: assert property (@(posedge clk2x) disable iff (standby)
      !xfer_now |=> $stable(hold_q)); // R8
   AST_LOAD_STABLE: assert property (@(posedge clk2x) disable iff (standby)
      !cap |=> $stable(load_q)); // R6
   AST_XFER_SEES_CAP: assert property (@(posedge clk2x) disable iff (standby)
      (xfer_now && cap) |=> (hold_q == $past(din))); // R9
   AST_STBY_CLEARS: assert property (@(posedge clk2x)
      standby |=> (hold_q == '0 && load_q == '0)); // R1
endmodule

// File: rtl/dseq_top.sv
module dseq_top #(
   parameter int N = 6,
   parameter int W = 10
) (
   input  logic           clk2x,
   input  logic           standby,
   input  logic [W-1:0]   din,
   input  logic           start_req,
   input  logic           edge_rise,
   input  logic           load_fwd,
   input  logic           xfer_req,
   output logic [N*W-1:0] chan_code,
   output logic           seq_busy
);
   localparam int BUS_W = N * W;

   generate
      if (N < 2) begin : g_bad_n
         $error("dseq_top: N must be at least 2");
      end
      if (W < 1) begin : g_bad_w
         $error("dseq_top: W must be at least 1");
      end
   endgenerate

   logic         rise_ev, fall_ev, act_ev;
   logic [N-1:0] cap_en;
   logic         pend_q;
   logic         xfer_now;

   dseq_phase u_phase (
      .clk2x(clk2x), .standby(standby), .edge_rise(edge_rise),
      .rise_ev(rise_ev), .fall_ev(fall_ev), .act_ev(act_ev)
   );

   dseq_ctrl #(.N(N)) u_ctrl (
      .clk2x(clk2x), .standby(standby), .act_ev(act_ev),
      .start_req(start_req), .load_fwd(load_fwd),
      .cap_en(cap_en), .busy(seq_busy)
   );

   always_ff @(posedge clk2x) begin
      if (standby)      pend_q <= 1'b0;
      else if (rise_ev) pend_q <= xfer_req;
      else              pend_q <= 1'b0;
   end

   assign xfer_now = fall_ev && pend_q;

   generate
      for (genvar k = 0; k < N; k++) begin : g_ch
         dseq_chan #(.W(W)) u_ch (
            .clk2x(clk2x), .standby(standby), .cap(cap_en[k]),
            .din(din), .xfer_now(xfer_now),
            .hold(chan_code[k*W +: W])
         );
      end
   endgenerate

   AST_XFER_COMMITS: assert property (@(posedge clk2x) disable iff (standby)
      (rise_ev && xfer_req) |=> xfer_now); // R8
   AST_NO_STRAY_XFER: assert property (@(posedge clk2x) disable iff (standby)
      !(rise_ev && xfer_req) |=> !xfer_now); // R8
   AST_STBY_IDLE: assert property (@(posedge clk2x)
      standby |=> (!seq_busy && chan_code == BUS_W'(0))); // R1
   AST_CAP_EDGE: assert property (@(posedge clk2x) disable iff (standby)
      (cap_en != '0) |-> (edge_rise ? rise_ev : fall_ev)); // R2
endmodule

// File: tb/sim_dseq_top.sv
module sim_dseq_top;
   localparam int N = 6;
   localparam int W = 10;

   logic           clk2x = 1'b0;
   logic           standby = 1'b1;
   logic [W-1:0]   din = '0;
   logic           start_req = 1'b0;
   logic           edge_rise = 1'b1;
   logic           load_fwd = 1'b1;
   logic           xfer_req = 1'b0;
   logic [N*W-1:0] chan_code;
   logic           seq_busy;

   int total = 0;
   int bad = 0;

   always #4 clk2x = ~clk2x;   // 125 MHz

   dseq_top #(.N(N), .W(W)) u0 (
      .clk2x(clk2x), .standby(standby), .din(din), .start_req(start_req),
      .edge_rise(edge_rise), .load_fwd(load_fwd), .xfer_req(xfer_req),
      .chan_code(chan_code), .seq_busy(seq_busy)
   );

   // reference model state
   logic [W-1:0] m_load [N];
   logic [W-1:0] m_hold [N];
   logic m_ph, m_arm, m_busy, m_dir, m_pend;
   int   m_step;

   function automatic int order_idx(input int s, input logic fwd);
      return fwd ? s : N - 1 - s;
   endfunction

   function automatic logic [N*W-1:0] m_flat();
      logic [N*W-1:0] v = '0;
      for (int k = 0; k < N; k++) v[k*W +: W] = m_hold[k];
      return v;
   endfunction

   task automatic model_edge();
      logic rise, act;
      if (standby) begin
         for (int k = 0; k < N; k++) begin m_load[k] = '0; m_hold[k] = '0; end
         m_ph = 0; m_arm = 0; m_busy = 0; m_dir = 0; m_pend = 0; m_step = 0;
         return;
      end
      rise = !m_ph;
      m_ph = !m_ph;
      act = edge_rise ? rise : !rise;
      if (act) begin
         if (m_arm) begin
            m_load[order_idx(0, load_fwd)] = din;
            m_dir = load_fwd; m_step = 1; m_busy = 1;
         end else if (m_busy) begin
            m_load[order_idx(m_step, m_dir)] = din;
            m_busy = (m_step != N - 1);
            m_step = m_step + 1;
         end
         m_arm = start_req;
      end
      if (!rise && m_pend)
         for (int k = 0; k < N; k++) m_hold[k] = m_load[k];
      m_pend = rise ? xfer_req : 1'b0;
   endtask

   task automatic compare(input string tag);
      total++;
      if (chan_code !== m_flat() || seq_busy !== m_busy) begin
         bad++;
         $display("FAIL %s: got code=%h busy=%b exp code=%h busy=%b",
                  tag, chan_code, seq_busy, m_flat(), m_busy);
      end
   endtask

   // drive at negedge, model at posedge, compare at next negedge
   task automatic tick(input logic sb, input logic st, input logic er,
                       input logic fw, input logic xf, input logic [W-1:0] d,
                       input string tag);
      standby = sb; start_req = st; edge_rise = er;
      load_fwd = fw; xfer_req = xf; din = d;
      @(posedge clk2x);
      model_edge();
      @(negedge clk2x);
      compare(tag);
   endtask

   // one pixel period (rise then fall tick) with the same controls
   task automatic pix(input logic st, input logic er, input logic fw,
                      input logic xf, input logic [W-1:0] d, input string tag);
      tick(1'b0, st, er, fw, xf, d, tag);
      tick(1'b0, st, er, fw, 1'b0, d, tag);
   endtask

   initial begin
      #1_000_000;
      total++; bad++;
      $display("FAIL watchdog: got running exp finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd7));
      @(negedge clk2x);
      // R1: standby clears everything
      for (int i = 0; i < 3; i++) tick(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 10'h3ff, "R1");

      // R2/R3/R4: forward fill on rising edges, then transfer (R8)
      pix(1'b1, 1'b1, 1'b1, 1'b0, 10'h000, "R3");
      for (int i = 0; i < N; i++) pix(1'b0, 1'b1, 1'b1, 1'b0, 10'(16 + i), "R4");
      pix(1'b0, 1'b1, 1'b1, 1'b1, 10'h000, "R8");
      pix(1'b0, 1'b1, 1'b1, 1'b0, 10'h155, "R6");
      pix(1'b0, 1'b1, 1'b1, 1'b1, 10'h0aa, "R6");
      total++;
      if (chan_code[0 +: W] !== 10'd16 || chan_code[(N-1)*W +: W] !== 10'(16 + N - 1)) begin
         bad++;
         $display("FAIL R4: got ch0=%0d chN=%0d exp %0d %0d",
                  chan_code[0 +: W], chan_code[(N-1)*W +: W], 16, 16 + N - 1);
      end

      // R2/R5: reverse fill on falling edges, direction toggled mid-sequence
      pix(1'b1, 1'b0, 1'b0, 1'b0, 10'h000, "R2");
      for (int i = 0; i < N; i++) pix(1'b0, 1'b0, (i % 2) == 1, 1'b0, 10'(200 + i), "R5");
      pix(1'b0, 1'b0, 1'b1, 1'b1, 10'h000, "R8");
      total++;
      if (chan_code[(N-1)*W +: W] !== 10'd200 || chan_code[0 +: W] !== 10'(200 + N - 1)) begin
         bad++;
         $display("FAIL R5: got chN=%0d ch0=%0d exp %0d %0d",
                  chan_code[(N-1)*W +: W], chan_code[0 +: W], 200, 200 + N - 1);
      end

      // R7: restart mid-sequence; R10: busy through the last capture
      pix(1'b1, 1'b1, 1'b1, 1'b0, 10'h000, "R7");
      pix(1'b0, 1'b1, 1'b1, 1'b0, 10'h011, "R10");
      pix(1'b1, 1'b1, 1'b1, 1'b0, 10'h012, "R7");
      for (int i = 0; i < N + 2; i++) pix(1'b0, 1'b1, 1'b1, 1'b0, 10'(300 + i), "R10");

      // R9: transfer on the falling edge that also captures (edge_rise=0)
      pix(1'b1, 1'b0, 1'b1, 1'b0, 10'h000, "R9");
      for (int i = 0; i < N - 1; i++) pix(1'b0, 1'b0, 1'b1, 1'b0, 10'(400 + i), "R9");
      tick(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 10'h1ee, "R9");
      tick(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 10'h1ef, "R9");
      total++;
      if (chan_code[(N-1)*W +: W] !== 10'h1ef) begin
         bad++;
         $display("FAIL R9: got %h exp %h", chan_code[(N-1)*W +: W], 10'h1ef);
      end

      // mixed random stimulus against the model
      for (int i = 0; i < 4000; i++) begin
         tick(($urandom % 97) == 0, ($urandom % 9) == 0, ($urandom % 40) != 0 ? edge_rise : !edge_rise,
              ($urandom % 2) == 1, ($urandom % 7) == 0, 10'($urandom), "R2");
      end
      for (int i = 0; i < 3; i++) tick(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 10'h3ff, "R1");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule